// File: doc/BRIEF.md
# Flash ADC thermometer-to-binary encoder

This block sits behind the comparator latches of a 6-bit flash converter. Each clock it takes the 63-bit thermometer word and returns a registered 6-bit binary code. It accepts one new sample on every clock edge and holds no state beyond its two pipeline stages.

A row of 3-input gates first turns the thermometer word into 64 transition lines. These gates also hide most single-bit comparator errors ("sparkles"). The lines are split into four groups of 16. Each group has its own encoder, which produces a 4-bit offset and a valid flag. The first register stage captures the group results. A select stage then picks the highest valid group, places its index above that group's offset, and the second register stage latches the final word.

Top module: `flash_therm_enc`

## Requirements
- R1: An active-low asynchronous reset clears both register stages, which forces code_o to 0 at once. The first clock edge after reset is released still shows 0. The code for the input sampled on that first edge appears on the second edge.
- R2: When therm_i is a clean thermometer word with n ones in bits n-1..0 and zeros above (n from 0 to 63), code_o equals n after the second rising edge following the sampling edge.
- R3: A new input is accepted on every clock. Back-to-back samples produce their codes on consecutive clocks, in input order.
- R4: Setting one stray 1 anywhere in the zero region of a clean word, at least two places above its top one, leaves code_o equal to n.
- R5: Clearing one 1 that lies three or more places below the top of a clean word leaves code_o equal to n.
- R6: Clearing the top one of a clean word gives n-1. Clearing the one just below the top gives n-2.
- R7: code_o[5:4] is a group index and code_o[3:0] is an offset within that group, so the selected line is 16*group+offset. When lines in several groups are active, the highest group wins. Within a group, the highest active line wins.
- R8: Transition line i (1..63) is active when input bits i-1 and i-2 are 1 and bit i is 0. Bit positions below 0 read as 1, and position 63 reads as 0. Line 0 is active when bit 0 is 0. If no line is active, the output is 0.
- R9: code_o never exceeds one plus the position of the highest set input bit sampled two clocks earlier.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Sample clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| therm_i | input | 63 | Thermometer word from the comparator latches, bit 0 lowest |
| code_o | output | 6 | Registered binary code, two clocks of latency |

## Verification
A fault in the first stage shows as a wrong offset or a wrong group bit two clocks after the sample. If the group flags are misregistered, the upper bits go wrong only when an edge crosses a 16-line boundary, so every clean level and every single-bit flip is driven. Faults in the sparkle gates show at the ports only for particular flip positions near the edge. The distance-based stray-bit rules therefore pin down each of those positions separately, with the expected code for each.

// File: rtl/flash_enc_pkg.sv
package flash_enc_pkg;
  localparam int unsigned CODE_W    = 6;
  localparam int unsigned GRP_W     = 4;
  localparam int unsigned SEL_W     = CODE_W - GRP_W;
  localparam int unsigned N_GRP     = 1 << SEL_W;
  localparam int unsigned GRP_LINES = 1 << GRP_W;
  localparam int unsigned N_LINE    = 1 << CODE_W;
  localparam int unsigned THERM_W   = N_LINE - 1;

  typedef struct packed {
    logic             valid;
    logic [GRP_W-1:0] offs;
  } grp_code_t;
endpackage

// File: rtl/flash_sparkle_gate.sv
module flash_sparkle_gate #(
  parameter int unsigned THERM_W = 63,
  parameter int unsigned N_LINE  = THERM_W + 1
) (
  input  logic [THERM_W-1:0] therm_i,
  output logic [N_LINE-1:0]  line_o
);
  localparam int unsigned EXT_W = THERM_W + 2;

  // ext[k] holds input bit k-1; the bit below 0 reads 1, the bit above the top reads 0
  logic [EXT_W-1:0] ext;
  assign ext = {1'b0, therm_i, 1'b1};

  assign line_o[0] = ~therm_i[0];

  for (genvar i = 1; i < N_LINE; i++) begin : g_line
    assign line_o[i] = ext[i] & ext[i-1] & ~ext[i+1];
  end
endmodule

// File: rtl/flash_group_enc.sv
module flash_group_enc
  import flash_enc_pkg::*;
#(
  parameter int unsigned W     = GRP_W,
  parameter int unsigned LINES = 1 << W
) (
  input  logic [LINES-1:0] line_i,
  output logic             valid_o,
  output logic [W-1:0]     offs_o
);
  assign valid_o = |line_i;

  // highest active line wins inside the group
  always_comb begin
    offs_o = '0;
    for (int k = 0; k < LINES; k++) begin
      if (line_i[k]) offs_o = W'(k);
    end
  end
endmodule

// File: rtl/flash_group_sel.sv
module flash_group_sel
  import flash_enc_pkg::*;
#(
  parameter int unsigned NG = N_GRP,
  parameter int unsigned SW = SEL_W,
  parameter int unsigned OW = GRP_W
) (
  input  grp_code_t          grp_i [NG],
  output logic [SW+OW-1:0]   code_o
);
  // highest valid group wins; none valid gives zero
  always_comb begin
    code_o = '0;
    for (int g = 0; g < NG; g++) begin
      if (grp_i[g].valid) code_o = {SW'(g), grp_i[g].offs};
    end
  end
endmodule

// File: rtl/flash_therm_enc.sv
module flash_therm_enc
  import flash_enc_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [THERM_W-1:0] therm_i,
  output logic [CODE_W-1:0]  code_o
);
  logic [N_LINE-1:0] line;
  grp_code_t         grp_d [N_GRP];
  grp_code_t         grp_q [N_GRP];
  logic [CODE_W-1:0] code_d;
  logic [CODE_W-1:0] code_q;

  flash_sparkle_gate #(
    .THERM_W(THERM_W),
    .N_LINE (N_LINE)
  ) gate_i (
    .therm_i(therm_i),
    .line_o (line)
  );

  for (genvar g = 0; g < N_GRP; g++) begin : g_grp
    logic             vld;
    logic [GRP_W-1:0] offs;

    flash_group_enc #(
      .W    (GRP_W),
      .LINES(GRP_LINES)
    ) enc_i (
      .line_i (line[g*GRP_LINES +: GRP_LINES]),
      .valid_o(vld),
      .offs_o (offs)
    );

    assign grp_d[g] = '{valid: vld, offs: offs};
  end

  // stage 1: per-group codes and flags
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int g = 0; g < N_GRP; g++) grp_q[g] <= '0;
    end else begin
      for (int g = 0; g < N_GRP; g++) grp_q[g] <= grp_d[g];
    end
  end

  flash_group_sel #(
    .NG(N_GRP),
    .SW(SEL_W),
    .OW(GRP_W)
  ) sel_i (
    .grp_i (grp_q),
    .code_o(code_d)
  );

  // stage 2: final word
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) code_q <= '0;
    else         code_q <= code_d;
  end

  assign code_o = code_q;
endmodule

// File: rtl/flash_therm_enc_chk.sv
module flash_therm_enc_chk
  import flash_enc_pkg::*;
(
  input logic               clk_i,
  input logic               rst_ni,
  input logic [THERM_W-1:0] therm_i,
  input logic [CODE_W-1:0]  code_o
);
  logic [1:0] age_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             age_q <= '0;
    else if (age_q != 2'd3)  age_q <= age_q + 2'd1;
  end

  function automatic logic is_clean(input logic [THERM_W-1:0] t);
    return (t & (t + THERM_W'(1))) == '0;
  endfunction

  function automatic int top_lim(input logic [THERM_W-1:0] t);
    int r = 0;
    for (int k = 0; k < int'(THERM_W); k++) if (t[k]) r = k + 1;
    return r;
  endfunction

  a_r1_reset_clear: assert property (@(posedge clk_i)
    !rst_ni |=> code_o == '0)
    else $error("R1 output not cleared by reset");

  a_r2_clean_code: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (age_q >= 2'd2 && is_clean($past(therm_i, 2)))
      |-> (int'(code_o) == $countones($past(therm_i, 2))))
    else $error("R2 clean word not encoded to its count");

  a_r9_ceiling: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (age_q >= 2'd2) |-> (int'(code_o) <= top_lim($past(therm_i, 2))))
    else $error("R9 output above highest set bit");

  a_r3_steady: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (age_q == 2'd3 && $past(therm_i, 2) == $past(therm_i, 3)) |-> $stable(code_o))
    else $error("R3 output moved for a held input");
endmodule

bind flash_therm_enc flash_therm_enc_chk chk_i (.*);

// File: tb/flash_therm_enc_tb_top.sv
`timescale 1ns/1ps
module flash_therm_enc_tb_top;
  import flash_enc_pkg::*;

  logic               clk_i = 1'b0;
  logic               rst_ni;
  logic [THERM_W-1:0] therm_i;
  logic [CODE_W-1:0]  code_o;

  int n_chk = 0;
  int n_err = 0;
  bit done  = 1'b0;

  always #2.5 clk_i = ~clk_i;

  flash_therm_enc dut_i (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .therm_i(therm_i),
    .code_o (code_o)
  );

  // directed corners: {therm, expected}
  localparam logic [THERM_W+CODE_W-1:0] DIR_VEC [6] = '{
    {63'h0000_0000_3FF0_03FF, 6'd30},  // R7 edges in groups 0 and 1
    {63'h0000_0000_0000_03CF, 6'd10},  // R7 two edges in group 0
    {63'h0006_0006_0006_0003, 6'd51},  // R7 an edge in every group
    {63'h5555_5555_5555_5555, 6'd1},   // R8 even bits set
    {63'h2AAA_AAAA_AAAA_AAAA, 6'd0},   // R8 odd bits set
    {63'h4000_0000_0000_0000, 6'd0}    // R8 lone top bit
  };

  function automatic logic [THERM_W-1:0] clean(input int n);
    return THERM_W'((64'd1 << n) - 64'd1);
  endfunction

  task automatic check(input string tag, input int got, input int exp);
    n_chk++;
    if (got != exp) begin
      n_err++;
      $display("FAIL %s: got %0d expected %0d", tag, got, exp);
    end
  endtask

  task automatic apply(input logic [THERM_W-1:0] t, input int exp, input string tag);
    @(negedge clk_i);
    therm_i = t;
    @(negedge clk_i);
    @(negedge clk_i);
    check(tag, int'(code_o), exp);
  endtask

  initial begin
    int seq [8] = '{5, 40, 0, 63, 17, 33, 16, 47};

    rst_ni  = 1'b0;
    therm_i = clean(63);
    repeat (3) @(negedge clk_i);
    check("R1", int'(code_o), 0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    check("R1", int'(code_o), 0);
    @(negedge clk_i);
    check("R1", int'(code_o), 63);

    for (int n = 0; n < int'(N_LINE); n++) apply(clean(n), n, "R2");

    for (int k = 0; k < 10; k++) begin
      @(negedge clk_i);
      if (k >= 2) check("R3", int'(code_o), seq[k-2]);
      if (k < 8) therm_i = clean(seq[k]);
    end

    for (int k = 0; k < 6; k++)
      apply(DIR_VEC[k][THERM_W+CODE_W-1:CODE_W], int'(DIR_VEC[k][CODE_W-1:0]),
            (k < 3) ? "R7" : "R8");

    for (int n = 0; n < int'(N_LINE); n++) begin
      for (int j = 0; j < int'(THERM_W); j++) begin
        if (j == n) continue;
        if (j > n)            apply(clean(n) ^ (THERM_W'(1) << j), n, "R4");
        else if (j == n - 1)  apply(clean(n) ^ (THERM_W'(1) << j), n - 1, "R6");
        else if (j == n - 2)  apply(clean(n) ^ (THERM_W'(1) << j), n - 2, "R6");
        else                  apply(clean(n) ^ (THERM_W'(1) << j), n, "R5");
      end
    end

    apply(clean(40), 40, "R2");
    @(negedge clk_i);
    #1 rst_ni = 1'b0;
    #0.5 check("R1", int'(code_o), 0);
    @(negedge clk_i);
    rst_ni = 1'b1;
    apply('0, 0, "R9");

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    #750000;
    if (!done) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end
endmodule